// File: doc/BRIEF.md
# Programming Pulse Width Generator

This block produces the write pulse that programs nonvolatile memory cells. A two-bit mode input chooses the source of the pulse. In strobe mode the output follows an active-low external strobe for as long as it is held. In software mode it follows a direct enable bit. In the two timed modes the length comes from one of two 16-bit count registers. The most significant bit of a count register must be 1, and its lower 15 bits hold the value. A timed pulse lasts (value + 1) units of 144 clock periods.

Both count registers are loaded through a simple write port. A timed pulse begins with a start request and holds `busy` high while it runs. The pulse length is captured when the pulse starts, so register writes made during a pulse only apply to later pulses. If a timed start finds the selected register without its top bit set, the block gives a one-cycle error flag and no pulse. At an 8 MHz clock a value of 5 gives 864 clocks (108 µs). At 16 MHz a value of 11 gives 1728 clocks (108 µs). Both meet the 100 µs minimum.

Top module: `pgm_pulse_gen`

## Requirements
- R1: After reset `busy` and `cfg_err` are 0, `pulse_out` is 0 in software mode with `soft_en` low, and the count registers hold their defaults: 16'h8005 for the auto register and 16'h800B for the serial register.
- R2: A timed start that is accepted raises `busy` and `pulse_out` from the cycle after `start`, and keeps both high for exactly (value + 1) × 144 cycles, where value is bits 14:0 of the selected register.
- R3: With `mode_sel` = 0 (strobe mode) and no timed pulse running, `pulse_out` equals the inverse of `strobe_n` in the same cycle, and `busy` stays 0.
- R4: With `mode_sel` = 3 (software mode) and no timed pulse running, `pulse_out` equals `soft_en` in the same cycle.
- R5: A start in a timed mode whose selected register has bit 15 clear raises `cfg_err` for exactly the next cycle and issues no pulse (`busy` stays 0).
- R6: A `start` that arrives while `busy` is high is ignored, and the running pulse keeps its length.
- R7: A register write made during a pulse does not change that pulse's length. The next pulse uses the new value.
- R8: `mode_sel` = 1 (auto) times from the register written with `wr_sel` = 0, and `mode_sel` = 2 (serial) times from the register written with `wr_sel` = 1. A write of `wr_data` happens on a clock edge when `wr_en` is high.
- R9: A `start` in strobe or software mode starts no timed pulse (`busy` stays 0).
- R10: Value 5 gives a timed pulse of 864 cycles and value 11 gives 1728 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 0 strobe, 1 auto, 2 serial, 3 software |
| strobe_n | input | 1 | Active-low external pulse strobe |
| soft_en | input | 1 | Software pulse enable |
| wr_en | input | 1 | Count register write strobe |
| wr_sel | input | 1 | 0 auto register, 1 serial register |
| wr_data | input | 16 | Write data, bit 15 must be 1 to be valid |
| start | input | 1 | Timed pulse start request |
| pulse_out | output | 1 | Programming pulse |
| busy | output | 1 | Timed pulse in progress |
| cfg_err | output | 1 | One-cycle flag for a rejected timed start |

## Verification
In strobe and software modes `pulse_out` is combinational, so the bench checks it one time step after changing the input, with no clock edge in between. A timed pulse starts one edge after `start` and lasts an exact number of cycles. The bench drives `start` on a falling edge, confirms `busy` at the next falling edge, and counts the falling edges while `busy` is high. It compares that count with (value + 1) × 144 from its own model of the registers. The bench checks `cfg_err` on the first falling edge after a rejected start and checks that it has cleared on the one after that. Random values, modes and top-bit settings are mixed with the directed 864- and 1728-cycle cases.

// File: rtl/pgm_pulse_pkg.sv
package pgm_pulse_pkg;
  typedef enum logic [1:0] {
    MODE_STROBE = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_SERIAL = 2'd2,
    MODE_SOFT   = 2'd3
  } pulse_mode_e;

  function automatic logic is_timed(input logic [1:0] m);
    return (m == MODE_AUTO) || (m == MODE_SERIAL);
  endfunction

  // Length of a timed pulse in clocks for a given count value
  function automatic int unsigned pulse_clocks(input int unsigned value,
                                               input int unsigned prescale);
    return (value + 1) * prescale;
  endfunction
endpackage

// File: rtl/pw_cfg_regs.sv
module pw_cfg_regs #(
  parameter int unsigned VAL_W = 15,
  parameter logic [VAL_W:0] DEF_AUTO = 16'h8005,
  parameter logic [VAL_W:0] DEF_SER  = 16'h800B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [VAL_W:0]   wr_data,
  output logic [VAL_W:0]   reg_auto,
  output logic [VAL_W:0]   reg_ser
);
  localparam int unsigned NREG = 2;
  logic [VAL_W:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [VAL_W:0] DEF = (i == 0) ? DEF_AUTO : DEF_SER;
    always_ff @(posedge clk) begin
      if (!rst_n)                         regs[i] <= DEF;
      else if (wr_en && (int'(wr_sel) == i)) regs[i] <= wr_data;
    end
  end

  assign reg_auto = regs[0];
  assign reg_ser  = regs[1];

  // R8: a write changes only the addressed register
  p_wr_isolate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> $stable(reg_ser));
endmodule

// File: rtl/pw_prescaler.sv
module pw_prescaler #(
  parameter int unsigned PRESCALE = 144,
  localparam int unsigned PW = $clog2(PRESCALE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic          tick,
  output logic [PW-1:0] cnt
);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (run)        cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R2: the prescaler never passes its wrap point
  p_pre_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/pw_unit_timer.sv
module pw_unit_timer #(
  parameter int unsigned VAL_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [VAL_W-1:0] load_val,
  input  logic             tick,
  output logic             active
);
  logic [VAL_W-1:0] units;
  logic             last_unit;

  assign last_unit = active && tick && (units == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      units  <= '0;
    end else if (launch) begin
      active <= 1'b1;
      units  <= load_val;
    end else if (active && tick) begin
      if (last_unit) active <= 1'b0;
      else           units  <= units - 1'b1;
    end
  end

  // R7: the remaining count only moves on a prescaler tick
  p_units_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !launch) |=> $stable(units));
endmodule

// File: rtl/pgm_pulse_gen.sv
module pgm_pulse_gen
  import pgm_pulse_pkg::*;
#(
  parameter int unsigned VAL_W    = 15,
  parameter int unsigned PRESCALE = 144,
  parameter logic [VAL_W:0] DEF_AUTO = 16'h8005,
  parameter logic [VAL_W:0] DEF_SER  = 16'h800B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode_sel,
  input  logic           strobe_n,
  input  logic           soft_en,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [VAL_W:0] wr_data,
  input  logic           start,
  output logic           pulse_out,
  output logic           busy,
  output logic           cfg_err
);
  localparam int unsigned PW = $clog2(PRESCALE);

  logic [VAL_W:0]  reg_auto, reg_ser, sel_reg;
  logic            start_req, launch, reject, tick;
  logic [PW-1:0]   pre_cnt;
  logic            mux_out;

  pw_cfg_regs #(.VAL_W(VAL_W), .DEF_AUTO(DEF_AUTO), .DEF_SER(DEF_SER)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .reg_auto(reg_auto), .reg_ser(reg_ser));

  assign sel_reg   = (mode_sel == MODE_SERIAL) ? reg_ser : reg_auto;
  assign start_req = start && !busy && is_timed(mode_sel);
  assign launch    = start_req && sel_reg[VAL_W];
  assign reject    = start_req && !sel_reg[VAL_W];

  pw_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(launch), .run(busy),
    .tick(tick), .cnt(pre_cnt));

  pw_unit_timer #(.VAL_W(VAL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .load_val(sel_reg[VAL_W-1:0]), .tick(tick), .active(busy));

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= reject;
  end

  always_comb begin
    unique case (mode_sel)
      MODE_STROBE: mux_out = !strobe_n;
      MODE_SOFT:   mux_out = soft_en;
      default:     mux_out = 1'b0;
    endcase
  end

  assign pulse_out = busy || mux_out;

  // Checker state: length of the running pulse versus the captured value
  logic [31:0]      len_cnt;
  logic [VAL_W-1:0] len_val;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_cnt <= '0;
      len_val <= '0;
    end else if (launch) begin
      len_cnt <= 32'd1;
      len_val <= sel_reg[VAL_W-1:0];
    end else if (busy) begin
      len_cnt <= len_cnt + 1'b1;
    end
  end

  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(len_cnt) == pulse_clocks(32'(len_val), PRESCALE)));
  p_first_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (pre_cnt == '0));
  p_err_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
  p_busy_drives_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pulse_out);
  p_rise_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && is_timed($past(mode_sel))));
endmodule

// File: tb/pgm_pulse_gen_bench.sv
module pgm_pulse_gen_bench;
  localparam int PRESCALE = 144;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd3;
  logic        strobe_n = 1'b1, soft_en = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic        pulse_out, busy, cfg_err;

  int errors = 0, checks = 0, cycles = 0;
  logic [15:0] m_reg [2];

  always #2 clk = ~clk;

  pgm_pulse_gen u_pgm_pulse_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .strobe_n(strobe_n),
    .soft_en(soft_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .pulse_out(pulse_out), .busy(busy), .cfg_err(cfg_err));

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic int exp_len(input logic [15:0] r);
    return (int'(r[14:0]) + 1) * PRESCALE;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_reg[sel] = d;
  endtask

  // action 0: none, 1: extra start mid-pulse, 2: write selected reg mid-pulse
  task automatic run_timed(input logic [1:0] m, input int action,
                           input logic [15:0] new_val, input string req);
    int n = 0;
    int exp = exp_len(m_reg[m == 2'd2]);
    bit good = m_reg[m == 2'd2][15];
    bit out_ok = 1'b1;
    @(negedge clk);
    mode_sel = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!good) begin
      check(cfg_err === 1'b1 && busy === 1'b0, "R5 err flag", int'(cfg_err), 1);
      @(negedge clk);
      check(cfg_err === 1'b0 && busy === 1'b0, "R5 err one cycle", int'(cfg_err), 0);
      return;
    end
    while (busy === 1'b1 && n < 40000) begin
      if (pulse_out !== 1'b1) out_ok = 1'b0;
      n++;
      if (action == 1 && n == 10) start = 1'b1;
      if (action == 1 && n == 11) start = 1'b0;
      if (action == 2 && n == 10) begin
        wr_en = 1'b1; wr_sel = (m == 2'd2); wr_data = new_val;
      end
      if (action == 2 && n == 11) wr_en = 1'b0;
      @(negedge clk);
    end
    if (action == 2) m_reg[m == 2'd2] = new_val;
    check(n == exp, req, n, exp);
    check(out_ok && cfg_err === 1'b0, "R2 pulse_out high during busy", int'(out_ok), 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_reg[0] = 16'h8005; m_reg[1] = 16'h800B;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && cfg_err === 1'b0 && pulse_out === 1'b0, "R1 reset outputs",
          int'({busy, cfg_err, pulse_out}), 0);
    // R10 / R8 defaults: auto 5 -> 864, serial 11 -> 1728
    run_timed(2'd1, 0, '0, "R10 value 5 -> 864 (R8 auto reg)");
    run_timed(2'd2, 0, '0, "R10 value 11 -> 1728 (R8 serial reg)");
    // R3 strobe mode
    @(negedge clk); mode_sel = 2'd0; strobe_n = 1'b0; #1;
    check(pulse_out === 1'b1, "R3 strobe low", int'(pulse_out), 1);
    strobe_n = 1'b1; #1;
    check(pulse_out === 1'b0, "R3 strobe high", int'(pulse_out), 0);
    // R9 start in strobe mode
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    check(busy === 1'b0, "R9 start in strobe mode", int'(busy), 0);
    // R4 software mode
    mode_sel = 2'd3; soft_en = 1'b1; #1;
    check(pulse_out === 1'b1, "R4 soft_en high", int'(pulse_out), 1);
    soft_en = 1'b0; #1;
    check(pulse_out === 1'b0, "R4 soft_en low", int'(pulse_out), 0);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    check(busy === 1'b0, "R9 start in soft mode", int'(busy), 0);
    // R5 top bit clear
    write_reg(1'b0, 16'h0003);
    run_timed(2'd1, 0, '0, "R5 rejected");
    // R6 start while busy
    write_reg(1'b0, 16'h8002);
    run_timed(2'd1, 1, '0, "R6 restart ignored");
    // R7 write during pulse
    run_timed(2'd1, 2, 16'h8006, "R7 current pulse keeps old length");
    run_timed(2'd1, 0, '0, "R7 next pulse uses new value");
    // random mix
    for (int i = 0; i < 24; i++) begin
      logic sel = 1'($urandom_range(0, 1));
      logic [15:0] d = {($urandom_range(0, 4) != 0) ? 1'b1 : 1'b0, 15'($urandom_range(0, 12))};
      write_reg(sel, d);
      run_timed($urandom_range(0, 1) ? 2'd2 : 2'd1, 0, '0, "R2 random timed pulse");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule